// File: doc/BRIEF.md
# Time-of-day hardware clock

A free-running precision-time counter for a network interface. Every rising edge of the system clock adds a per-cycle period (whole nanoseconds plus a 16-bit binary fraction of a nanosecond) to the current time. The time is presented in two forms that always agree. The first is a split form: seconds, nanoseconds within the second, and the fraction. The second is a flat count of nanoseconds with the same fraction.

A one-cycle pulse-per-second strobe marks every change of the seconds field. A drift input can add one extra fractional unit at a programmable cadence. This trims a period that the 16-bit fraction cannot represent exactly. Servo control, loading the time from outside and packet timestamp capture belong to other blocks.

Top module: `ptp_tod_clock`

## Requirements
- R1: While rst_ni is low, tod_o, flat_o and pps_o are all zero.
- R2: tod_o packs seconds in [95:48], nanoseconds in [47:16] and 2^-16 ns units in [15:0]. The nanoseconds field never reaches 1,000,000,000; on reaching or passing it, the field drops by 1,000,000,000 and seconds gain one in the same cycle.
- R3: flat_o packs total nanoseconds in [63:16] and 2^-16 ns units in [15:0]. Each rising edge adds {inc_ns_i, inc_fns_i} plus any drift unit to it.
- R4: A carry out of the 16-bit fraction adds one nanosecond in both formats in the same cycle.
- R5: If only the fraction carry pushes nanoseconds to 1,000,000,000, the result is nanoseconds 0 with seconds incremented, in that same cycle.
- R6: tod_o[15:0] equals flat_o[15:0], and flat_o[63:16] equals seconds*1,000,000,000 + nanoseconds on every cycle.
- R7: pps_o is high for exactly the cycles in which the seconds field differs from its value one cycle earlier.
- R8: With drift_rate_i = N > 0, held since reset, one extra fractional unit is added on the first edge after reset and then on every Nth edge. The drift counter reloads to N-1 each time it reaches zero.
- R9: With drift_rate_i = 0, no extra unit is ever added, so a zero increment leaves the time unchanged.
- R10: flat_o never decreases.
- R11: With a 6 ns + 0x6666 increment and no drift, flat_o after 10,000 edges is exactly 4,194,300,000.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| inc_ns_i | input | 30 | Whole nanoseconds added per cycle (must be below 1,000,000,000) |
| inc_fns_i | input | 16 | Fractional nanoseconds added per cycle, 2^-16 ns units |
| drift_rate_i | input | 16 | Cadence N of the extra fractional unit; 0 disables it |
| tod_o | output | 96 | Seconds / nanoseconds / fraction time |
| flat_o | output | 64 | Flat nanoseconds / fraction time |
| pps_o | output | 1 | One-cycle strobe on a change of seconds |

## Verification
Every output is registered, so the increment applied at one edge is visible in tod_o, flat_o and pps_o right after that edge, with no further delay. The bench drives the increment on the falling edge and updates its arithmetic model at the rising edge. It compares all three outputs at the next falling edge, one cycle per stimulus. The pps check compares the model's seconds with the model's own seconds from the previous edge. The drift model counts edges from reset release, so the first extra unit is expected on the first compared cycle.

// File: rtl/ptp_tod_pkg.sv
package ptp_tod_pkg;
  localparam int unsigned SEC_W     = 48;
  localparam int unsigned NS_W      = 32;
  localparam int unsigned FNS_W     = 16;
  localparam int unsigned FLAT_NS_W = 48;
  localparam int unsigned TOD_W     = SEC_W + NS_W + FNS_W;
  localparam int unsigned FLAT_W    = FLAT_NS_W + FNS_W;
  localparam logic [NS_W:0] NS_PER_SEC = 33'd1_000_000_000;
endpackage

// File: rtl/ptp_drift_gen.sv
module ptp_drift_gen #(
  parameter int unsigned DRIFT_W = 16
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic [DRIFT_W-1:0] rate_i,
  output logic               extra_o
);
  logic [DRIFT_W-1:0] cnt_q;

  assign extra_o = (rate_i != '0) && (cnt_q == '0);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)               cnt_q <= '0;
    else if (rate_i == '0)     cnt_q <= '0;
    else if (cnt_q == '0)      cnt_q <= rate_i - 1'b1;
    else                       cnt_q <= cnt_q - 1'b1;
  end

  // R8
  drift_reload_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    extra_o |=> cnt_q == $past(rate_i) - 1'b1);
endmodule

// File: rtl/ptp_flat_ctr.sv
module ptp_flat_ctr
  import ptp_tod_pkg::*;
#(
  parameter int unsigned INC_NS_W = 30
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic [INC_NS_W-1:0] inc_ns_i,
  input  logic [FNS_W-1:0]    inc_fns_i,
  input  logic                extra_i,
  output logic [FLAT_W-1:0]   ts_o
);
  logic [FLAT_W-1:0] step;

  assign step = {(FLAT_NS_W)'(inc_ns_i), inc_fns_i} + FLAT_W'(extra_i);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) ts_o <= '0;
    else         ts_o <= ts_o + step;
  end

  // R10
  flat_monotonic_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    1'b1 |=> ts_o >= $past(ts_o));
endmodule

// File: rtl/ptp_tod_ctr.sv
module ptp_tod_ctr
  import ptp_tod_pkg::*;
#(
  parameter int unsigned INC_NS_W = 30
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic [INC_NS_W-1:0] inc_ns_i,
  input  logic [FNS_W-1:0]    inc_fns_i,
  input  logic                extra_i,
  output logic [SEC_W-1:0]    sec_o,
  output logic [NS_W-1:0]     ns_o,
  output logic [FNS_W-1:0]    fns_o,
  output logic                sec_step_o
);
  logic [FNS_W:0] fsum;
  logic [NS_W:0]  nsum;
  logic [NS_W:0]  nwrap;
  logic           wrap;

  assign fsum       = {1'b0, fns_o} + {1'b0, inc_fns_i} + (FNS_W+1)'(extra_i);
  assign nsum       = {1'b0, ns_o} + (NS_W+1)'(inc_ns_i) + (NS_W+1)'(fsum[FNS_W]);
  assign wrap       = nsum >= NS_PER_SEC;
  assign nwrap      = nsum - NS_PER_SEC;
  assign sec_step_o = wrap;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sec_o <= '0;
      ns_o  <= '0;
      fns_o <= '0;
    end else begin
      fns_o <= fsum[FNS_W-1:0];
      ns_o  <= wrap ? nwrap[NS_W-1:0] : nsum[NS_W-1:0];
      sec_o <= sec_o + SEC_W'(wrap);
    end
  end

  // R2
  ns_range_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    {1'b0, ns_o} < NS_PER_SEC);
  // R2
  sec_step_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    1'b1 |=> (sec_o == $past(sec_o)) || (sec_o == $past(sec_o) + 1'b1));
endmodule

// File: rtl/ptp_tod_clock.sv
module ptp_tod_clock
  import ptp_tod_pkg::*;
#(
  parameter int unsigned INC_NS_W = 30,
  parameter int unsigned DRIFT_W  = 16
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic [INC_NS_W-1:0] inc_ns_i,
  input  logic [15:0]         inc_fns_i,
  input  logic [DRIFT_W-1:0]  drift_rate_i,
  output logic [95:0]         tod_o,
  output logic [63:0]         flat_o,
  output logic                pps_o
);
  logic             extra;
  logic [SEC_W-1:0] sec;
  logic [NS_W-1:0]  ns;
  logic [FNS_W-1:0] fns;
  logic             sec_step;

  ptp_drift_gen #(.DRIFT_W(DRIFT_W)) u_drift (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .rate_i (drift_rate_i),
    .extra_o(extra)
  );

  ptp_flat_ctr #(.INC_NS_W(INC_NS_W)) u_flat (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .inc_ns_i (inc_ns_i),
    .inc_fns_i(inc_fns_i),
    .extra_i  (extra),
    .ts_o     (flat_o)
  );

  ptp_tod_ctr #(.INC_NS_W(INC_NS_W)) u_tod (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .inc_ns_i  (inc_ns_i),
    .inc_fns_i (inc_fns_i),
    .extra_i   (extra),
    .sec_o     (sec),
    .ns_o      (ns),
    .fns_o     (fns),
    .sec_step_o(sec_step)
  );

  assign tod_o = {sec, ns, fns};

  // strobe registered on the same edge that moves seconds
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) pps_o <= 1'b0;
    else         pps_o <= sec_step;
  end

  // R6
  frac_match_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    tod_o[15:0] == flat_o[15:0]);
  // R6
  ns_match_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    flat_o[63:16] == tod_o[95:48] * 48'd1_000_000_000 + 48'(tod_o[47:16]));
  // R7
  pps_sec_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    1'b1 |=> pps_o == (tod_o[95:48] != $past(tod_o[95:48])));
endmodule

// File: tb/ptp_tod_clock_tb.sv
module ptp_tod_clock_tb;
  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic [29:0] inc_ns_i = '0;
  logic [15:0] inc_fns_i = '0;
  logic [15:0] drift_rate_i = '0;
  logic [95:0] tod_o;
  logic [63:0] flat_o;
  logic        pps_o;

  int errors = 0;
  int checks = 0;
  logic [63:0] exp_flat;
  logic [47:0] exp_prev_sec;
  logic [15:0] exp_dcnt;
  logic [63:0] last_flat;

  always #4 clk_i = ~clk_i;

  ptp_tod_clock u_dut (
    .clk_i(clk_i), .rst_ni(rst_ni), .inc_ns_i(inc_ns_i), .inc_fns_i(inc_fns_i),
    .drift_rate_i(drift_rate_i), .tod_o(tod_o), .flat_o(flat_o), .pps_o(pps_o)
  );

  task automatic chk(input string req, input logic [95:0] act, input logic [95:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic do_reset(input logic [15:0] rate);
    @(negedge clk_i);
    rst_ni = 1'b0;
    drift_rate_i = rate;
    inc_ns_i = 30'd7;
    inc_fns_i = 16'h1234;
    exp_flat = '0; exp_prev_sec = '0; exp_dcnt = '0; last_flat = '0;
    @(negedge clk_i);
    @(negedge clk_i);
    // R1
    chk("R1 tod", tod_o, '0);
    chk("R1 flat", 96'(flat_o), '0);
    chk("R1 pps", 96'(pps_o), '0);
    rst_ni = 1'b1;
  endtask

  // called at a falling edge; returns at the next falling edge after checking
  task automatic tick(input logic [29:0] n, input logic [15:0] f);
    logic [47:0] sec;
    logic [47:0] nsv;
    logic        extra;
    inc_ns_i = n;
    inc_fns_i = f;
    @(posedge clk_i);
    extra = (drift_rate_i != 0) && (exp_dcnt == 0);
    if (drift_rate_i == 0)  exp_dcnt = 0;
    else if (exp_dcnt == 0) exp_dcnt = drift_rate_i - 16'd1;
    else                    exp_dcnt = exp_dcnt - 16'd1;
    exp_flat = exp_flat + {18'd0, n, f} + 64'(extra);
    @(negedge clk_i);
    sec = exp_flat[63:16] / 48'd1_000_000_000;
    nsv = exp_flat[63:16] % 48'd1_000_000_000;
    // R3 R4 R8 R9
    chk("R3", 96'(flat_o), 96'(exp_flat));
    // R2 R6
    chk("R2", tod_o, {sec, nsv[31:0], exp_flat[15:0]});
    // R7
    chk("R7", 96'(pps_o), 96'(sec != exp_prev_sec));
    // R10
    if (flat_o < last_flat) chk("R10", 96'(flat_o), 96'(last_flat));
    last_flat = flat_o;
    exp_prev_sec = sec;
  endtask

  initial begin
    #(8 * 200000);
    errors++;
    $display("FAIL watchdog actual=running expected=done");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    do_reset(16'd0);
    // R3 R4: sweep fractions, carries into ns
    for (int i = 0; i < 4096; i++) tick(30'd3, 16'(i * 16 + 5));
    // R2 R7: repeated second crossings
    for (int i = 0; i < 300; i++) tick(30'd123_456_789, 16'hABCD);
    for (int i = 0; i < 20; i++) tick(30'd999_999_999, 16'hFFFF);

    // R5: fraction carry alone reaches 1e9
    do_reset(16'd0);
    tick(30'd999_999_999, 16'hFFFF);
    tick(30'd0, 16'h0001);
    chk("R5 ns", 96'(tod_o[47:16]), 96'd0);
    chk("R5 sec", 96'(tod_o[95:48]), 96'd1);
    chk("R5 pps", 96'(pps_o), 96'd1);
    tick(30'd0, 16'h0000);
    chk("R7 single", 96'(pps_o), 96'd0);

    // R8: rate 3, zero increment, extras at edges 1,4,7,10
    do_reset(16'd3);
    for (int i = 0; i < 10; i++) tick(30'd0, 16'h0000);
    chk("R8 rate3", 96'(flat_o), 96'd4);
    do_reset(16'd1);
    for (int i = 0; i < 7; i++) tick(30'd0, 16'h0000);
    chk("R8 rate1", 96'(flat_o), 96'd7);
    for (int n = 2; n < 9; n++) begin
      do_reset(16'(n));
      for (int i = 0; i < 40; i++) tick(30'd5, 16'hFFFF);
    end

    // R9: no drift, zero increment
    do_reset(16'd0);
    for (int i = 0; i < 8; i++) tick(30'd0, 16'h0000);
    chk("R9", 96'(flat_o), 96'd0);

    // R11: 6.4 ns period
    do_reset(16'd0);
    for (int i = 0; i < 10000; i++) tick(30'd6, 16'h6666);
    chk("R11", 96'(flat_o), 96'd4_194_300_000);

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule